// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block takes interrupt messages from a single source and decides which of `NCPU` processors should receive each one. Every message carries a vector and a two-bit delivery mode. In fixed mode the message names its destination. In broadcast mode every enabled processor gets it. In lowest-priority mode the router compares the task-priority values that the processors report and picks the enabled processor with the smallest value. Ties among the lowest values are settled by a rotating pointer, so interrupt load spreads across equally idle processors.

Messages are accepted through a valid/ready handshake. One cycle after acceptance the router drives a one-hot (or, for broadcast, multi-hot) per-processor deliver strobe together with the vector. If no processor qualifies, it instead raises a one-cycle error pulse. An enable mask removes processors from consideration in every mode.

Top module: `lp_irq_router`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `dlv_strobe` is all zero, `dlv_error` is low and `msg_ready` is low. From the second cycle after release onward, `msg_ready` is high.
- R2: A message is accepted in a cycle where `msg_valid` and `msg_ready` are both high. Its result appears on the outputs in the following cycle and lasts one cycle. A cycle with no acceptance is followed by an all-zero strobe and a low error.
- R3: In fixed mode (`msg_mode` = 0), when `msg_dest` is below `NCPU` and that processor is enabled, only bit `msg_dest` of `dlv_strobe` is set.
- R4: In lowest-priority mode (`msg_mode` = 1), exactly one strobe bit is set. It belongs to an enabled processor whose 4-bit priority, taken from `cpu_prio[i*4 +: 4]`, is the smallest among the enabled processors.
- R5: Among tied lowest-priority candidates, the winner is the first one found searching upward, with wrap-around, from a rotating pointer. After that delivery the pointer becomes the winner index plus one, modulo `NCPU`. Reset sets the pointer to 0.
- R6: Fixed, broadcast, reserved-mode and failed messages leave the rotating pointer unchanged.
- R7: In broadcast mode (`msg_mode` = 2), `dlv_strobe` equals `cpu_enable` as it was when the message was accepted.
- R8: A disabled processor is never strobed. A fixed destination that is disabled or at least `NCPU`, and a lowest-priority or broadcast message with no enabled processor, produce a one-cycle `dlv_error` pulse and no strobe.
- R9: Mode code 3 is reserved. It produces a `dlv_error` pulse and no strobe.
- R10: Whenever any strobe bit is set, `dlv_vector` holds the vector of the accepted message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Router can take a message |
| msg_vector | input | VEC_W | Interrupt vector |
| msg_mode | input | 2 | 0 fixed, 1 lowest priority, 2 broadcast, 3 reserved |
| msg_dest | input | IDX_W | Destination index for fixed mode |
| cpu_prio | input | NCPU*PRIO_W | Packed task-priority values, processor i at bits i*PRIO_W upward |
| cpu_enable | input | NCPU | Per-processor eligibility mask |
| dlv_strobe | output | NCPU | Per-processor deliver strobe |
| dlv_vector | output | VEC_W | Vector accompanying the strobe |
| dlv_error | output | 1 | Message dropped, no eligible target |

## Verification
The bench builds the router with five processors rather than the default four. A non-power-of-two count exercises the modulo wrap of the rotating pointer. It also leaves three-bit destination codes 5 to 7 that must be rejected as out of range. Priority values are drawn from a narrow range so that ties among several processors are common. The enable mask is sometimes all zero, which reaches the empty-candidate error path in every mode.

// File: rtl/lp_irq_router.sv
module lp_irq_router #(
  parameter int NCPU   = 4,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msg_valid,
  output logic                   msg_ready,
  input  logic [VEC_W-1:0]       msg_vector,
  input  logic [1:0]             msg_mode,
  input  logic [IDX_W-1:0]       msg_dest,
  input  logic [NCPU*PRIO_W-1:0] cpu_prio,
  input  logic [NCPU-1:0]        cpu_enable,
  output logic [NCPU-1:0]        dlv_strobe,
  output logic [VEC_W-1:0]       dlv_vector,
  output logic                   dlv_error
);
  localparam logic [1:0] MODE_FIXED = 2'd0;
  localparam logic [1:0] MODE_LOW   = 2'd1;
  localparam logic [1:0] MODE_BCAST = 2'd2;

  logic              ready_q;
  logic [IDX_W-1:0]  rr_ptr;
  logic [PRIO_W-1:0] min_p;
  logic [NCPU-1:0]   tie;
  logic              found;
  int                win;
  logic [NCPU-1:0]   nxt_strobe;
  logic              nxt_err;
  logic              adv;
  logic              accept;

  assign msg_ready = ready_q;
  assign accept    = msg_valid && ready_q;

  always_comb begin
    min_p = '1;
    for (int i = 0; i < NCPU; i++)
      if (cpu_enable[i] && cpu_prio[i*PRIO_W +: PRIO_W] < min_p)
        min_p = cpu_prio[i*PRIO_W +: PRIO_W];
    for (int i = 0; i < NCPU; i++)
      tie[i] = cpu_enable[i] && (cpu_prio[i*PRIO_W +: PRIO_W] == min_p);
  end

  always_comb begin
    found = 1'b0;
    win   = 0;
    for (int k = 0; k < NCPU; k++) begin
      int idx;
      idx = (int'(rr_ptr) + k) % NCPU;
      if (!found && tie[idx]) begin
        found = 1'b1;
        win   = idx;
      end
    end
  end

  always_comb begin
    nxt_strobe = '0;
    nxt_err    = 1'b0;
    adv        = 1'b0;
    case (msg_mode)
      MODE_FIXED: begin
        for (int i = 0; i < NCPU; i++)
          if (i == int'(msg_dest) && cpu_enable[i]) nxt_strobe[i] = 1'b1;
        nxt_err = (nxt_strobe == '0);
      end
      MODE_LOW: begin
        for (int i = 0; i < NCPU; i++)
          if (found && i == win) nxt_strobe[i] = 1'b1;
        nxt_err = !found;
        adv     = found;
      end
      MODE_BCAST: begin
        nxt_strobe = cpu_enable;
        nxt_err    = (cpu_enable == '0);
      end
      default: nxt_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      rr_ptr     <= '0;
      dlv_strobe <= '0;
      dlv_vector <= '0;
      dlv_error  <= 1'b0;
    end else begin
      ready_q    <= 1'b1;
      dlv_strobe <= accept ? nxt_strobe : '0;
      dlv_error  <= accept && nxt_err;
      if (accept) dlv_vector <= msg_vector;
      if (accept && adv) rr_ptr <= IDX_W'((win + 1) % NCPU);
    end
  end
endmodule

module lp_irq_router_chk #(
  parameter int NCPU   = 4,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   msg_valid,
  input logic                   msg_ready,
  input logic [VEC_W-1:0]       msg_vector,
  input logic [1:0]             msg_mode,
  input logic [IDX_W-1:0]       msg_dest,
  input logic [NCPU*PRIO_W-1:0] cpu_prio,
  input logic [NCPU-1:0]        cpu_enable,
  input logic [NCPU-1:0]        dlv_strobe,
  input logic [VEC_W-1:0]       dlv_vector,
  input logic                   dlv_error
);
  logic acc;
  assign acc = msg_valid && msg_ready;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc) |-> (dlv_strobe == '0 && !dlv_error));

  // R8
  strobe_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_strobe & ~$past(cpu_enable)) == '0);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_error |-> dlv_strobe == '0);

  // R3
  fixed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && msg_mode == 2'd0) |-> $onehot0(dlv_strobe));

  // R4
  low_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && msg_mode == 2'd1) |-> ($countones(dlv_strobe) == 1 || dlv_error));

  // R9
  reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && msg_mode == 2'd3) |-> dlv_error);

  // R10
  vector_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_strobe != '0) |-> dlv_vector == $past(msg_vector));
endmodule

bind lp_irq_router lp_irq_router_chk #(.NCPU(NCPU), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) i_chk (.*);

// File: tb/test_lp_irq_router.sv
`timescale 1ns/1ps
module test_lp_irq_router;
  localparam int NC = 5;
  localparam int PW = 4;
  localparam int VW = 8;
  localparam int DW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msg_valid = 1'b0;
  logic          msg_ready;
  logic [VW-1:0] msg_vector = '0;
  logic [1:0]    msg_mode = '0;
  logic [DW-1:0] msg_dest = '0;
  logic [NC*PW-1:0] cpu_prio = '0;
  logic [NC-1:0] cpu_enable = '1;
  logic [NC-1:0] dlv_strobe;
  logic [VW-1:0] dlv_vector;
  logic          dlv_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lp_irq_router #(.NCPU(NC), .PRIO_W(PW), .VEC_W(VW)) i_lp_irq_router (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(input int mode, input int dest,
      input logic [NC*PW-1:0] p, input logic [NC-1:0] en, input int rr,
      output logic [NC-1:0] s, output bit e, output int nrr, output string tag);
    int cand[$];
    int best;
    s = '0; e = 0; nrr = rr; tag = "R2";
    best = 99;
    for (int i = 0; i < NC; i++)
      if (en[i] && int'(p[i*PW +: PW]) < best) best = int'(p[i*PW +: PW]);
    for (int k = 0; k < NC; k++) begin
      int j = (rr + k) % NC;
      if (en[j] && int'(p[j*PW +: PW]) == best) cand.push_back(j);
    end
    if (mode == 0) begin
      tag = "R3";
      if (dest < NC && en[dest]) s[dest] = 1'b1; else begin e = 1; tag = "R8"; end
    end else if (mode == 1) begin
      tag = "R5";
      if (cand.size() > 0) begin s[cand[0]] = 1'b1; nrr = (cand[0] + 1) % NC; end
      else begin e = 1; tag = "R8"; end
    end else if (mode == 2) begin
      tag = "R7";
      s = en;
      if (en == '0) begin e = 1; tag = "R8"; end
    end else begin
      e = 1; tag = "R9";
    end
  endfunction

  logic [NC-1:0] exp_s;
  bit            exp_e;
  logic [VW-1:0] exp_v;
  string         exp_tag;
  int            rr;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_s <= '0; exp_e <= 0; rr <= 0; exp_tag <= "R1";
    end else if (msg_valid && msg_ready) begin
      logic [NC-1:0] s; bit e; int n; string t;
      model(int'(msg_mode), int'(msg_dest), cpu_prio, cpu_enable, rr, s, e, n, t);
      exp_s <= s; exp_e <= e; rr <= n; exp_v <= msg_vector; exp_tag <= t;
    end else begin
      exp_s <= '0; exp_e <= 0; exp_tag <= "R2";
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({exp_tag, " strobe"}, int'(dlv_strobe), int'(exp_s));
      check({exp_tag, " error"}, int'(dlv_error), int'(exp_e));
      if (exp_s != '0) check("R10 vector", int'(dlv_vector), int'(exp_v));
    end
  end

  task automatic send(input int mode, input int dest, input int vec);
    @(negedge clk);
    msg_valid = 1'b1; msg_mode = 2'(mode); msg_dest = DW'(dest); msg_vector = VW'(vec);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic send_chk(input int mode, input int dest, input int vec,
                          input int exp_strobe, input int exp_err, input string req);
    send(mode, dest, vec);
    check({req, " directed strobe"}, int'(dlv_strobe), exp_strobe);
    check({req, " directed error"}, int'(dlv_error), exp_err);
  endtask

  task automatic set_prio(input int a0, a1, a2, a3, a4);
    cpu_prio = {PW'(a4), PW'(a3), PW'(a2), PW'(a1), PW'(a0)};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 strobe in reset", int'(dlv_strobe), 0);
    check("R1 error in reset", int'(dlv_error), 0);
    check("R1 ready in reset", int'(msg_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready after reset", int'(msg_ready), 1);

    cpu_enable = 5'b11111;
    set_prio(3, 3, 3, 3, 3);
    send_chk(1, 0, 8'h40, 5'b00001, 0, "R5");
    send_chk(1, 0, 8'h41, 5'b00010, 0, "R5");
    send_chk(0, 4, 8'h42, 5'b10000, 0, "R3");
    send_chk(2, 0, 8'h43, 5'b11111, 0, "R7");
    send_chk(3, 0, 8'h44, 5'b00000, 1, "R9");
    send_chk(1, 0, 8'h45, 5'b00100, 0, "R6");
    set_prio(3, 3, 3, 1, 3);
    send_chk(1, 0, 8'h46, 5'b01000, 0, "R4");
    set_prio(3, 3, 3, 3, 3);
    cpu_enable = 5'b01111;
    send_chk(1, 0, 8'h47, 5'b00001, 0, "R5");
    send_chk(0, 4, 8'h48, 5'b00000, 1, "R8");
    send_chk(0, 6, 8'h49, 5'b00000, 1, "R8");
    cpu_enable = 5'b00000;
    send_chk(2, 0, 8'h4a, 5'b00000, 1, "R8");
    send_chk(1, 0, 8'h4b, 5'b00000, 1, "R8");
    cpu_enable = 5'b01010;
    send_chk(2, 0, 8'h4c, 5'b01010, 0, "R7");

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      msg_valid  = ($urandom_range(0, 3) != 0);
      msg_mode   = 2'($urandom_range(0, 3));
      msg_dest   = DW'($urandom_range(0, 7));
      msg_vector = VW'($urandom);
      cpu_enable = ($urandom_range(0, 9) == 0) ? '0 : NC'($urandom);
      for (int i = 0; i < NC; i++) cpu_prio[i*PW +: PW] = PW'($urandom_range(0, 3));
    end
    @(negedge clk);
    msg_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule